// File: doc/BRIEF.md
# Memory-Mapped GPIO Pin Bank

This block controls a bank of up to 64 general-purpose pins through a small register interface with a read strobe and a write strobe. Software never writes the output data directly. Ones written to the set address turn output bits on, and ones written to the clear address turn them off. Zero bits leave the matching outputs unchanged, so two agents can update different pins without a read-modify-write race.

Every pin has its own configuration word, which holds four things: an output-enable bit, a polarity-invert bit, an open-drain bit and a pin-function field. The invert bit is XORed into both the driven value and the sampled value. In open-drain mode the pin is only ever pulled low, and it is released when the effective output is 1. A nonzero function field hands the pin to another function, so the GPIO driver is switched off. Pin inputs pass through a two-flop synchronizer before software can read them. A read-only constant register reports how many pins are implemented.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset the output data register and every configuration word are zero, `pin_oe` is all zeros and `rdata` is zero.
- R2: A write to byte offset 0x008 sets each output data bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R3: A write to byte offset 0x010 clears each output data bit whose `wdata` bit is 1 and leaves the other bits unchanged.
- R4: A read at offset 0x008 returns the output data register. `rdata` is loaded on the clock edge that samples `rd_en` and holds its value while `rd_en` is low.
- R5: A read at offset 0x000 returns, for each pin, the value of `pin_in` after a two-flop synchronizer, XORed with that pin's invert bit. A change on `pin_in` becomes visible to a read issued two cycles later.
- R6: Pin p has a configuration word at offset 0x400 + 8*p with these fields: bit 0 is output enable, bit 1 is invert, bit 12 is open-drain, and bits 25:16 are the function select. A read of the word returns those fields, and all other bits read as zero.
- R7: When the function select is zero and open-drain is 0, `pin_out[p]` equals the output data bit XOR the invert bit, and `pin_oe[p]` equals the output-enable bit.
- R8: When the function select is zero and open-drain is 1, `pin_out[p]` is 0 and `pin_oe[p]` is the output-enable bit AND NOT (output data bit XOR invert bit).
- R9: When the function select is nonzero, `pin_oe[p]` and `pin_out[p]` are both 0, whatever the other fields hold.
- R10: A read at offset 0x090 returns NPINS in bits 7:0, with all other bits zero.
- R11: Writes to offsets 0x000 and 0x090, to unmapped offsets, or to offsets that are not a multiple of 8 change no state. Reads at unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; rdata is loaded on the same edge |
| addr | input | 11 | Byte offset of the access |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Output value of each pin's driver |
| pin_oe | output | NPINS | Output enable of each pin's driver |

## Verification
The assertions assume that `wr_en`, `rd_en`, `addr` and `wdata` always carry known values, and that reset is held low across at least one rising edge before the first access. The bench meets this by driving every input only on falling edges, starting from defined values, and holding reset low for several cycles. It also takes for granted that `pin_in` stays stable for two edges before a read that depends on it. So the random phase always waits after changing `pin_in` before it reads the input register.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int DATA_W  = 64;
  localparam int ADDR_W  = 11;
  localparam int FUNC_W  = 10;
  localparam int FUNC_LSB = 16;
  localparam int OE_BIT  = 0;
  localparam int INV_BIT = 1;
  localparam int OD_BIT  = 12;

  localparam logic [ADDR_W-1:0] OFS_IN    = 11'h000;
  localparam logic [ADDR_W-1:0] OFS_SET   = 11'h008;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 11'h010;
  localparam logic [ADDR_W-1:0] OFS_CONST = 11'h090;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 11'h400;

  typedef struct packed {
    logic [FUNC_W-1:0] func;
    logic              od;
    logic              inv;
    logic              oe;
  } pin_cfg_t;

  function automatic pin_cfg_t cfg_unpack(logic [DATA_W-1:0] w);
    pin_cfg_t c;
    c.func = w[FUNC_LSB +: FUNC_W];
    c.od   = w[OD_BIT];
    c.inv  = w[INV_BIT];
    c.oe   = w[OE_BIT];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_pack(pin_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[FUNC_LSB +: FUNC_W] = c.func;
    w[OD_BIT]  = c.od;
    w[INV_BIT] = c.inv;
    w[OE_BIT]  = c.oe;
    return w;
  endfunction

  // returns {value, enable} for one pin's tri-state driver
  function automatic logic [1:0] pin_drive(pin_cfg_t c, logic dat);
    logic eff;
    eff = dat ^ c.inv;
    if (c.func != '0)  return 2'b00;
    else if (c.od)     return {1'b0, c.oe & ~eff};
    else               return {eff, c.oe};
  endfunction
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int NPINS = 64,
  localparam int IDX_W = ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NPINS-1:0]  out_data,
  output pin_cfg_t          cfg_q [NPINS],
  output logic              set_hit,
  output logic              clr_hit,
  output logic              cfg_sel,
  output logic [IDX_W-1:0]  cfg_idx
);
  localparam int CFG_SPAN = 8 * NPINS;

  logic              aligned;
  logic [ADDR_W-1:0] cfg_off;

  assign aligned = (addr[2:0] == 3'b000);
  assign cfg_off = addr - OFS_CFG;
  assign cfg_idx = cfg_off[ADDR_W-1:3];
  assign cfg_sel = aligned && (addr >= OFS_CFG) && (int'(cfg_off) < CFG_SPAN);
  assign set_hit = wr_en && (addr == OFS_SET);
  assign clr_hit = wr_en && (addr == OFS_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n)       out_data <= '0;
    else if (set_hit) out_data <= out_data | wdata[NPINS-1:0];
    else if (clr_hit) out_data <= out_data & ~wdata[NPINS-1:0];
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q[p] <= '0;
      else if (wr_en && cfg_sel && (cfg_idx == IDX_W'(p)))
        cfg_q[p] <= cfg_unpack(wdata);
    end
  end
endmodule

// File: rtl/pinbank_drive.sv
module pinbank_drive
  import pinbank_pkg::*;
#(
  parameter int NPINS = 64
) (
  input  pin_cfg_t         cfg_q [NPINS],
  input  logic [NPINS-1:0] out_data,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] drv;
    assign drv        = pin_drive(cfg_q[p], out_data[p]);
    assign pin_out[p] = drv[1];
    assign pin_oe[p]  = drv[0];
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NPINS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [10:0]       addr,
  input  logic [63:0]       wdata,
  output logic [63:0]       rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe
);
  localparam int IDX_W = ADDR_W - 3;

  logic [NPINS-1:0] out_data;
  pin_cfg_t         cfg_q [NPINS];
  logic             set_hit, clr_hit, cfg_sel;
  logic [IDX_W-1:0] cfg_idx;
  logic [NPINS-1:0] in_sync;

  // named per-pin views for the checker
  logic [NPINS-1:0] inv_mask, od_mask, sel_mask;
  for (genvar p = 0; p < NPINS; p++) begin : g_mask
    assign inv_mask[p] = cfg_q[p].inv;
    assign od_mask[p]  = cfg_q[p].od;
    assign sel_mask[p] = (cfg_q[p].func != '0);
  end

  pinbank_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .out_data(out_data), .cfg_q(cfg_q), .set_hit(set_hit), .clr_hit(clr_hit),
    .cfg_sel(cfg_sel), .cfg_idx(cfg_idx)
  );

  pinbank_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(in_sync)
  );

  pinbank_drive #(.NPINS(NPINS)) u_drive (
    .cfg_q(cfg_q), .out_data(out_data), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  logic [DATA_W-1:0] rd_val, cfg_word;

  always_comb begin
    cfg_word = '0;
    for (int p = 0; p < NPINS; p++)
      if (cfg_idx == IDX_W'(p)) cfg_word = cfg_pack(cfg_q[p]);
  end

  always_comb begin
    rd_val = '0;
    if (cfg_sel)                 rd_val = cfg_word;
    else if (addr == OFS_IN)     rd_val = DATA_W'(in_sync ^ inv_mask);
    else if (addr == OFS_SET)    rd_val = DATA_W'(out_data);
    else if (addr == OFS_CONST)  rd_val = DATA_W'(8'(NPINS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
  parameter int NPINS = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [10:0]      addr,
  input logic [63:0]      wdata,
  input logic [63:0]      rdata,
  input logic [NPINS-1:0] out_data,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] od_mask,
  input logic [NPINS-1:0] sel_mask
);
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_data == '0) && (pin_oe == '0) && (rdata == '0));

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 11'h008) |=>
      ((out_data & $past(wdata[NPINS-1:0])) == $past(wdata[NPINS-1:0])) &&
      ((out_data & $past(out_data)) == $past(out_data)));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 11'h010) |=>
      ((out_data & $past(wdata[NPINS-1:0])) == '0) &&
      ((out_data & ~$past(out_data)) == '0));

  p_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 11'h008) |=> (rdata == 64'($past(out_data))));

  p_od_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & od_mask) == '0);

  p_func_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe | pin_out) & sel_mask) == '0);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (addr != 11'h008 && addr != 11'h010)) |=> $stable(out_data));

  p_rdhold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind pinbank_ctrl pinbank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .out_data(out_data), .pin_out(pin_out),
  .pin_oe(pin_oe), .od_mask(od_mask), .sel_mask(sel_mask)
);

// File: tb/sim_pinbank_ctrl.sv
module sim_pinbank_ctrl;
  localparam int N = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [10:0]   addr = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;

  int n_chk = 0, n_bad = 0;

  // bench model
  logic [N-1:0] m_out;
  logic         m_oe [N];
  logic         m_inv [N];
  logic         m_od [N];
  logic [9:0]   m_fn [N];

  always #10 clk = ~clk;   // 50 MHz

  pinbank_ctrl #(.NPINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [63:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  function automatic logic [63:0] cfg_word(int p);
    return {38'b0, m_fn[p], 3'b0, m_od[p], 10'b0, m_inv[p], m_oe[p]};
  endfunction

  function automatic logic [N-1:0] inv_vec();
    logic [N-1:0] v;
    for (int p = 0; p < N; p++) v[p] = m_inv[p];
    return v;
  endfunction

  // expected driver state, written from the requirement text
  function automatic logic [2*N-1:0] exp_pins();
    logic [N-1:0] o, e;
    for (int p = 0; p < N; p++) begin
      logic lvl;
      lvl = m_out[p] ^ m_inv[p];
      o[p] = 1'b0; e[p] = 1'b0;
      if (m_fn[p] == 10'd0) begin
        if (!m_od[p]) begin o[p] = lvl; e[p] = m_oe[p]; end
        else          e[p] = m_oe[p] && !lvl;
      end
    end
    return {o, e};
  endfunction

  task automatic chk_pins(input string tag);
    logic [2*N-1:0] x;
    x = exp_pins();
    chk({tag, " pin_out"}, 64'(pin_out), 64'(x[2*N-1:N]));
    chk({tag, " pin_oe"},  64'(pin_oe),  64'(x[N-1:0]));
  endtask

  task automatic cfg_wr(input int p, input logic [63:0] w);
    wr(11'h400 + 11'(8 * p), w);
    m_oe[p] = w[0]; m_inv[p] = w[1]; m_od[p] = w[12]; m_fn[p] = w[25:16];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] r, w;
    void'($urandom(32'd4417));
    m_out = '0;
    for (int p = 0; p < N; p++) begin m_oe[p]=0; m_inv[p]=0; m_od[p]=0; m_fn[p]='0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", 64'(pin_oe), 64'd0);
    chk("R1 rdata", rdata, 64'd0);
    rd(11'h008, r); chk("R1 out data", r, 64'd0);
    rd(11'h400 + 11'd8 * 11'd63, r); chk("R1 cfg", r, 64'd0);

    // R10 constant
    rd(11'h090, r); chk("R10 const", r, 64'(N));

    // R2 / R3 directed
    wr(11'h008, 64'h0000_00F0_0000_000F); m_out |= 64'h0000_00F0_0000_000F;
    wr(11'h008, 64'h8000_0000_0000_0001); m_out |= 64'h8000_0000_0000_0001;
    rd(11'h008, r); chk("R2 set", r, m_out);
    wr(11'h010, 64'h0000_0010_0000_0003); m_out &= ~64'h0000_0010_0000_0003;
    rd(11'h008, r); chk("R3 clr", r, m_out);
    chk("R4 hold", rdata, m_out);

    // R6 config field readback
    cfg_wr(7, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(11'h400 + 11'd56, r); chk("R6 cfg fields", r, 64'h0000_0000_03FF_1003);
    cfg_wr(7, 64'h0);

    // R7 push-pull with invert
    cfg_wr(2, 64'h3); cfg_wr(3, 64'h1);
    chk_pins("R7 push-pull");

    // R8 open drain
    cfg_wr(4, 64'h1001);
    chk_pins("R8 od low"); chk("R8 od enable", 64'(pin_oe[4]), 64'(!m_out[4]));
    wr(11'h008, 64'h10); m_out[4] = 1'b1;
    chk("R8 od release", 64'(pin_oe[4]), 64'd0);

    // R9 function select
    cfg_wr(5, 64'h0001_0003);
    chk("R9 func oe", 64'(pin_oe[5]), 64'd0);
    chk("R9 func out", 64'(pin_out[5]), 64'd0);

    // R5 input with invert
    @(negedge clk); pin_in = 64'hA5A5_0000_FFFF_1234;
    repeat (2) @(negedge clk);
    rd(11'h000, r); chk("R5 input", r, pin_in ^ inv_vec());

    // R11 ignored writes
    w = m_out;
    wr(11'h090, '1); wr(11'h000, '1); wr(11'h018, '1); wr(11'h00C, '1);
    wr(11'h404, '1); wr(11'h7F0 + 11'd8, '1);
    rd(11'h008, r); chk("R11 out data", r, w);
    rd(11'h400, r); chk("R11 cfg0", r, cfg_word(0));
    rd(11'h400 + 11'd8, r); chk("R11 cfg1", r, cfg_word(1));
    rd(11'h090, r); chk("R11 const", r, 64'(N));
    rd(11'h018, r); chk("R11 unmapped read", r, 64'd0);
    chk_pins("R11 pins");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op, p;
      op = $urandom % 6;
      w = {$urandom, $urandom};
      p = $urandom % N;
      case (op)
        0: begin wr(11'h008, w); m_out |= w; chk_pins("R2 R7 R8 R9 rand"); end
        1: begin wr(11'h010, w); m_out &= ~w; chk_pins("R3 R7 R8 R9 rand"); end
        2: begin
          if ($urandom % 4 != 0) w[25:16] = '0;
          cfg_wr(p, w); chk_pins("R7 R8 R9 rand");
        end
        3: begin rd(11'h008, r); chk("R4 rand", r, m_out); end
        4: begin rd(11'h400 + 11'(8 * p), r); chk("R6 rand", r, cfg_word(p)); end
        default: begin
          @(negedge clk); pin_in = w;
          repeat (2) @(negedge clk);
          rd(11'h000, r); chk("R5 rand", r, pin_in ^ inv_vec());
        end
      endcase
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule